// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This unit sits beside a memory controller's ECC check path and turns its error events into status, captured addresses and signalling levels. Each event carries an address, a syndrome and two qualifiers: whether the error could be corrected and whether the read came from the scrubber. From these the event is sorted into one of three types: correctable, uncorrectable on a normal read, or uncorrectable found by the scrubber.

Two status registers hold the types seen. The first-error register takes a bit only when it is fully clear. Any later error goes to the next-error register. Logging registers hold address (and, for correctable errors, syndrome). Each log is frozen by a specific status bit, so software finds the earliest error and not the latest one. Clearing the status bits frees the logs again. Software can mask each type, which stops it being recorded at all. Any type can also be routed to any of four level outputs: system error, system-management interrupt, configuration interrupt and machine check. All of this goes through a small word-addressed register port.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, both status registers, the mask, the route register and every log read as zero, and all four signalling outputs are low.
- R2: An event with ev_uncorr=0 is type 0 (correctable), whatever ev_scrub is. ev_uncorr=1 with ev_scrub=0 is type 1. ev_uncorr=1 with ev_scrub=1 is type 2. The type number is the bit position in the status, mask and route fields.
- R3: A recognised event sets its type bit in the first-error register (offset 0) only if that register is all zero. Otherwise it sets the bit in the next-error register (offset 1).
- R4: The primary correctable log (address at offset 4, syndrome at offset 5) loads on every recognised type 0 event while first-error bit 0 is clear. It holds its value while that bit is set.
- R5: The secondary correctable log (address at offset 6, syndrome at offset 7) loads on every recognised type 0 event while next-error bit 0 is clear. It holds its value while that bit is set.
- R6: The uncorrectable address log (offset 8) loads on type 1 events while bit 1 is clear in both status registers. The scrub address log (offset 9) does the same for type 2 events and bit 2.
- R7: While mask bit t (offset 2, bit t) is set, a type t event changes no status bit and no log. Status bits of masked types do not drive any output.
- R8: Writing to offset 0 or 1 clears the status bits written as 1 and leaves the bits written as 0. If a new event sets a bit in the same cycle as a clear, the bit ends up set.
- R9: Once the locking status bit has been cleared, a log loads again on the next recognised event of its type.
- R10: Output o (0 system error, 1 management interrupt, 2 configuration interrupt, 3 machine check) is high while some type t has route bit 3*o+t set at offset 3, a status bit set in either register, and its mask bit clear.
- R11: The mask and route registers read back what was written, in the low 3 and 12 bits. Unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One error event this cycle |
| ev_uncorr | input | 1 | Event was not correctable |
| ev_scrub | input | 1 | Event came from a scrubber read |
| ev_addr | input | AW | Address of the failing access |
| ev_syn | input | SW | ECC syndrome of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sig_serr | output | 1 | System-error level |
| sig_smi | output | 1 | Management-interrupt level |
| sig_sci | output | 1 | Configuration-interrupt level |
| sig_mce | output | 1 | Machine-check level |

## Verification
The assertions assume at most one event per cycle and that the event qualifiers are meaningful only when ev_valid is high. The first-error register's single-bit property depends on this. The bench drives one event per cycle and returns ev_valid to low between events. It writes registers only at the offsets listed, and raises a write and an event together only in the case that tests a clear racing a new error. Reset is applied once, before any stimulus.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int NTYPE = 3;
    localparam int NSIG  = 4;
    localparam int RW    = 32;
    localparam int RTW   = NTYPE * NSIG;

    localparam int IDX_CE  = 0;
    localparam int IDX_UE  = 1;
    localparam int IDX_SCB = 2;

    localparam logic [3:0] OFS_FIRST   = 4'd0;
    localparam logic [3:0] OFS_NEXT    = 4'd1;
    localparam logic [3:0] OFS_MASK    = 4'd2;
    localparam logic [3:0] OFS_ROUTE   = 4'd3;
    localparam logic [3:0] OFS_CEF_ADR = 4'd4;
    localparam logic [3:0] OFS_CEF_SYN = 4'd5;
    localparam logic [3:0] OFS_CEN_ADR = 4'd6;
    localparam logic [3:0] OFS_CEN_SYN = 4'd7;
    localparam logic [3:0] OFS_UE_ADR  = 4'd8;
    localparam logic [3:0] OFS_SCB_ADR = 4'd9;

    typedef struct packed {
        logic [NTYPE-1:0] first;
        logic [NTYPE-1:0] next;
        logic [NTYPE-1:0] mask;
        logic [RTW-1:0]   route;
    } ctl_t;
endpackage

// File: rtl/ecc_cap_ctl.sv
module ecc_cap_ctl
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTYPE-1:0] hit,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [RTW-1:0]   wr_data,
    output logic [NTYPE-1:0] rec,
    output logic [NTYPE-1:0] first_q,
    output logic [NTYPE-1:0] next_q,
    output logic [NTYPE-1:0] mask_q,
    output logic [RTW-1:0]   route_q
);
    ctl_t ctl_d, ctl_q;

    assign rec     = hit & ~ctl_q.mask;
    assign first_q = ctl_q.first;
    assign next_q  = ctl_q.next;
    assign mask_q  = ctl_q.mask;
    assign route_q = ctl_q.route;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            case (wr_addr)
                OFS_FIRST: ctl_d.first = ctl_q.first & ~wr_data[NTYPE-1:0];
                OFS_NEXT:  ctl_d.next  = ctl_q.next  & ~wr_data[NTYPE-1:0];
                OFS_MASK:  ctl_d.mask  = wr_data[NTYPE-1:0];
                OFS_ROUTE: ctl_d.route = wr_data;
                default: ;
            endcase
        end
        if (|rec) begin
            if (ctl_q.first == '0) ctl_d.first = ctl_d.first | rec;
            else                   ctl_d.next  = ctl_d.next  | rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assert_first_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_q.first));

    assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rec) && ctl_q.first == '0) |=> ctl_q.first == $past(rec));

    assert_later_to_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rec) && ctl_q.first != '0) |=> (ctl_q.next & $past(rec)) == $past(rec));

    assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rec) && !wr_en) |=> ($stable(ctl_q.first) && $stable(ctl_q.next)));
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load) data_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;

    assert_log_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(data_q));
endmodule

// File: rtl/ecc_cap_route.sv
module ecc_cap_route
    import ecc_cap_pkg::*;
(
    input  logic [NTYPE-1:0] status,
    input  logic [NTYPE-1:0] mask,
    input  logic [RTW-1:0]   route,
    output logic [NSIG-1:0]  sig
);
    logic [NTYPE-1:0] live;
    assign live = status & ~mask;

    for (genvar o = 0; o < NSIG; o++) begin : g_sig
        assign sig[o] = |(live & route[o*NTYPE +: NTYPE]);
    end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic          ev_uncorr,
    input  logic          ev_scrub,
    input  logic [AW-1:0] ev_addr,
    input  logic [SW-1:0] ev_syn,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          sig_serr,
    output logic          sig_smi,
    output logic          sig_sci,
    output logic          sig_mce
);
    localparam int CW = AW + SW;

    logic [NTYPE-1:0] hit, rec, first_q, next_q, mask_q;
    logic [RTW-1:0]   route_q;
    logic [NSIG-1:0]  sig;
    logic [CW-1:0]    cef_q, cen_q;
    logic [AW-1:0]    ue_q, scb_q;
    logic             ld_cef, ld_cen, ld_ue, ld_scb;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[RW-1:RTW];

    always_comb begin
        hit = '0;
        if (ev_valid) begin
            if (!ev_uncorr)   hit[IDX_CE]  = 1'b1;
            else if (ev_scrub) hit[IDX_SCB] = 1'b1;
            else              hit[IDX_UE]  = 1'b1;
        end
    end

    ecc_cap_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata[RTW-1:0]),
        .rec     (rec),
        .first_q (first_q),
        .next_q  (next_q),
        .mask_q  (mask_q),
        .route_q (route_q)
    );

    assign ld_cef = rec[IDX_CE]  & ~first_q[IDX_CE];
    assign ld_cen = rec[IDX_CE]  & ~next_q[IDX_CE];
    assign ld_ue  = rec[IDX_UE]  & ~(first_q[IDX_UE]  | next_q[IDX_UE]);
    assign ld_scb = rec[IDX_SCB] & ~(first_q[IDX_SCB] | next_q[IDX_SCB]);

    ecc_cap_log #(.W(CW)) u_log_cef (
        .clk (clk), .rst_n (rst_n), .load (ld_cef),
        .din ({ev_addr, ev_syn}), .dout (cef_q)
    );
    ecc_cap_log #(.W(CW)) u_log_cen (
        .clk (clk), .rst_n (rst_n), .load (ld_cen),
        .din ({ev_addr, ev_syn}), .dout (cen_q)
    );
    ecc_cap_log #(.W(AW)) u_log_ue (
        .clk (clk), .rst_n (rst_n), .load (ld_ue),
        .din (ev_addr), .dout (ue_q)
    );
    ecc_cap_log #(.W(AW)) u_log_scb (
        .clk (clk), .rst_n (rst_n), .load (ld_scb),
        .din (ev_addr), .dout (scb_q)
    );

    ecc_cap_route u_route (
        .status (first_q | next_q),
        .mask   (mask_q),
        .route  (route_q),
        .sig    (sig)
    );

    assign sig_serr = sig[0];
    assign sig_smi  = sig[1];
    assign sig_sci  = sig[2];
    assign sig_mce  = sig[3];

    always_comb begin
        case (reg_addr)
            OFS_FIRST:   reg_rdata = RW'(first_q);
            OFS_NEXT:    reg_rdata = RW'(next_q);
            OFS_MASK:    reg_rdata = RW'(mask_q);
            OFS_ROUTE:   reg_rdata = RW'(route_q);
            OFS_CEF_ADR: reg_rdata = RW'(cef_q[CW-1:SW]);
            OFS_CEF_SYN: reg_rdata = RW'(cef_q[SW-1:0]);
            OFS_CEN_ADR: reg_rdata = RW'(cen_q[CW-1:SW]);
            OFS_CEN_SYN: reg_rdata = RW'(cen_q[SW-1:0]);
            OFS_UE_ADR:  reg_rdata = RW'(ue_q);
            OFS_SCB_ADR: reg_rdata = RW'(scb_q);
            default:     reg_rdata = '0;
        endcase
    end

    assert_cef_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        first_q[IDX_CE] |=> $stable(cef_q));

    assert_cen_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        next_q[IDX_CE] |=> $stable(cen_q));

    assert_ue_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q[IDX_UE] | next_q[IDX_UE]) |=> $stable(ue_q));

    assert_route_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|sig) |-> (((first_q | next_q) & ~mask_q) != '0));
endmodule

// File: tb/ecc_err_capture_tb.sv
`timescale 1ns/1ps
module ecc_err_capture_tb;
    localparam int AW = 32;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0, ev_uncorr = 1'b0, ev_scrub = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [SW-1:0] ev_syn = '0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          sig_serr, sig_smi, sig_sci, sig_mce;

    typedef struct {
        bit          is_sig;
        logic [3:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    logic [31:0] act;

    always #2 clk = ~clk;

    ecc_err_capture #(.AW(AW), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
        .ev_scrub(ev_scrub), .ev_addr(ev_addr), .ev_syn(ev_syn), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sig_serr(sig_serr), .sig_smi(sig_smi), .sig_sci(sig_sci), .sig_mce(sig_mce)
    );

    // monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            act = it.is_sig ? {28'd0, sig_mce, sig_sci, sig_smi, sig_serr} : reg_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s sig=%0b ofs=%0d actual=%h expected=%h",
                         it.req, it.is_sig, it.addr, act, it.exp);
            end
        end
    end

    task automatic ev(input bit u, input bit s, input logic [31:0] a, input logic [7:0] y);
        @(negedge clk);
        ev_valid = 1'b1; ev_uncorr = u; ev_scrub = s; ev_addr = a; ev_syn = y;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_ev(input logic [3:0] a, input logic [31:0] d,
                         input bit u, input bit s, input logic [31:0] ad);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        ev_valid = 1'b1; ev_uncorr = u; ev_scrub = s; ev_addr = ad; ev_syn = '0;
        @(negedge clk);
        reg_wr = 1'b0; ev_valid = 1'b0;
    endtask

    // driver: pushes an expected register value for the monitor
    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string req);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_sig = 1'b0; it.addr = a; it.exp = e; it.req = req;
        sb_q.push_back(it);
        #2;
    endtask

    // expected output vector {mce, sci, smi, serr}
    task automatic chk_sig(input logic [3:0] e, input string req);
        item_t it;
        @(negedge clk);
        it.is_sig = 1'b1; it.addr = '0; it.exp = {28'd0, e}; it.req = req;
        sb_q.push_back(it);
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 10; i++) chk(4'(i), 32'h0, "R1 reset register");
        chk_sig(4'b0000, "R1 reset outputs");

        // R2/R3/R4 first correctable error
        ev(1'b0, 1'b0, 32'hA000_0010, 8'h11);
        chk(4'd0, 32'h1, "R3 first gets bit0");
        chk(4'd1, 32'h0, "R3 next clear");
        chk(4'd4, 32'hA000_0010, "R4 primary CE address");
        chk(4'd5, 32'h11, "R4 primary CE syndrome");

        // R2 scrub correctable counts as type 0; R3 goes to next
        ev(1'b0, 1'b1, 32'hA000_0020, 8'h22);
        chk(4'd1, 32'h1, "R2 R3 scrub CE to next bit0");
        chk(4'd4, 32'hA000_0010, "R4 primary CE held");
        chk(4'd6, 32'hA000_0020, "R5 secondary CE address");
        chk(4'd7, 32'h22, "R5 secondary CE syndrome");

        // R4 R5 both locked
        ev(1'b0, 1'b0, 32'hA000_0030, 8'h33);
        chk(4'd4, 32'hA000_0010, "R4 primary still held");
        chk(4'd6, 32'hA000_0020, "R5 secondary held");
        chk(4'd7, 32'h22, "R5 secondary syndrome held");

        // R2 R6 uncorrectable demand read
        ev(1'b1, 1'b0, 32'hB000_0040, 8'h00);
        chk(4'd1, 32'h3, "R2 UE sets next bit1");
        chk(4'd8, 32'hB000_0040, "R6 UE address");
        ev(1'b1, 1'b0, 32'hB000_0050, 8'h00);
        chk(4'd8, 32'hB000_0040, "R6 UE log held");

        // R2 R6 scrubber uncorrectable
        ev(1'b1, 1'b1, 32'hC000_0060, 8'h00);
        chk(4'd1, 32'h7, "R2 scrub UE sets next bit2");
        chk(4'd9, 32'hC000_0060, "R6 scrub address");
        ev(1'b1, 1'b1, 32'hC000_0070, 8'h00);
        chk(4'd9, 32'hC000_0060, "R6 scrub log held");
        chk(4'd0, 32'h1, "R3 first unchanged");

        // R10 routing: serr<-t0, smi<-t1, sci<-t2, mce<-t1|t2
        wr(4'd3, 32'h0000_0D11);
        chk(4'd3, 32'h0000_0D11, "R11 route readback");
        chk_sig(4'b1111, "R10 all routed");
        wr(4'd2, 32'h2);
        chk(4'd2, 32'h2, "R11 mask readback");
        chk_sig(4'b1101, "R7 R10 masked type1 drops smi");

        // R8 write-one-to-clear
        wr(4'd0, 32'h0);
        chk(4'd0, 32'h1, "R8 zero write keeps first");
        wr(4'd1, 32'h1);
        chk(4'd1, 32'h6, "R8 clear next bit0 only");
        wr(4'd0, 32'h1);
        chk(4'd0, 32'h0, "R8 clear first");

        // R9 unlock after clear; first empty so R3 goes to first
        ev(1'b0, 1'b0, 32'hA000_0080, 8'h88);
        chk(4'd0, 32'h1, "R3 cleared first takes bit0");
        chk(4'd1, 32'h6, "R3 next unchanged");
        chk(4'd4, 32'hA000_0080, "R9 primary reloads");
        chk(4'd6, 32'hA000_0080, "R9 secondary reloads");
        chk(4'd7, 32'h88, "R9 secondary syndrome reloads");

        // R7 masked type 1 does nothing, even with log unlocked
        wr(4'd1, 32'h6);
        chk(4'd1, 32'h0, "R8 next cleared");
        ev(1'b1, 1'b0, 32'hB000_0090, 8'h00);
        chk(4'd1, 32'h0, "R7 masked no status");
        chk(4'd0, 32'h1, "R7 masked first unchanged");
        chk(4'd8, 32'hB000_0040, "R7 masked no log");

        // R9 unmask, UE log updates again
        wr(4'd2, 32'h0);
        ev(1'b1, 1'b0, 32'hB000_00A0, 8'h00);
        chk(4'd1, 32'h2, "R3 UE to next");
        chk(4'd8, 32'hB000_00A0, "R9 UE reloads");

        // R8 clear and new error same cycle: new error wins
        wr_ev(4'd1, 32'h2, 1'b1, 1'b0, 32'hB000_00B0);
        chk(4'd1, 32'h2, "R8 new error wins");
        chk(4'd8, 32'hB000_00A0, "R6 UE locked during race");
        chk_sig(4'b1011, "R10 first t0 next t1");

        chk(4'd12, 32'h0, "R11 unused offset");

        done = 1'b1;
        @(negedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule